// File: doc/BRIEF.md
# Serial Write-Only Register Control Port

This block is a slave control port that takes register writes from a host over three serial wires: an active-low select, a bit clock and a data-in line. A frame opens with a 7-bit device address and a direction flag. The port only answers frames whose device address equals one of three addresses it holds in its own register file: an individual address and two group addresses. The two group addresses let one frame reach several devices at once. There is no data-out line, so any frame flagged as a read is treated as foreign.

After an accepted header, the next byte sets a register pointer and an auto-increment enable. Every further complete byte is written into a 128-entry by 8-bit register file at the pointer. The three match addresses live in that register file, so the host can move a device to a new address, or into and out of groups, through the port itself. The serial wires are brought into the faster system clock through two-flop synchronizers, and all edges are detected in that clock. Each register write is shown for one cycle on a strobe with its address and data.

Top module: `spi_regport`

## Requirements
- R1: After reset, wr_stb is low, the individual match address is 40h, the group 1 match address is 7Fh and the group 2 match address is 7Eh. These are the low seven bits of registers 1Bh, 1Ah and 19h. All other registers reset to 00h.
- R2: Bits are sampled on the rising edge of spi_sck while spi_sel_n is low, most significant bit first. A falling edge of spi_sel_n starts a frame. The first seven bits are the device address, and the eighth bit is the direction flag, where 0 means write.
- R3: A write-flagged frame is accepted when its device address equals the individual, group 1 or group 2 match address.
- R4: A frame whose direction flag is 1, or whose device address matches none of the three, produces no write for any later bits until spi_sel_n goes high and then low again.
- R5: In an accepted frame, the second byte carries the auto-increment enable in bit 7 and the target register in bits 6:0. Each later complete byte is written to the pointed register and shown on wr_stb for exactly one cycle, with wr_addr and wr_data.
- R6: With auto-increment at 0, the pointer does not change, so successive data bytes write the same register.
- R7: With auto-increment at 1, the pointer advances by one after each data byte and wraps from 7Fh to 00h.
- R8: A write to register 1Bh, 1Ah or 19h changes the matching address for later frames.
- R9: spi_sel_n going high drops any partial byte without writing it, returns the port to idle and clears the bit count, so the next frame starts aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than spi_sck |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | Active-low frame select from the host |
| spi_sck | input | 1 | Serial bit clock from the host |
| spi_sdi | input | 1 | Serial data from the host |
| wr_stb | output | 1 | One-cycle pulse for each register write |
| wr_addr | output | 7 | Register written when wr_stb is high |
| wr_data | output | 8 | Data written when wr_stb is high |

## Verification
Damage to the bit counter or the frame state shows up at the write port within the next byte. The symptoms are a strobe with a shifted address or data, a strobe in a frame that should be locked out, or a strobe that is missing. A stale pointer shows up on the second data byte of a frame as a wrong wr_addr. A corrupted match register does not show up until a later frame, which is then refused or wrongly accepted. The bench therefore follows each reprogramming write with frames to both the old and the new address.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  localparam int DEV_W  = 7;
  localparam int BYTE_W = 8;
  localparam int REG_AW = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHIP,
    ST_PTR,
    ST_DATA,
    ST_LOCK
  } frame_st_t;

  // true when the received device address equals any of the three match addresses
  function automatic logic chip_hit(input logic [DEV_W-1:0] rx,
                                    input logic [DEV_W-1:0] ind,
                                    input logic [DEV_W-1:0] g1,
                                    input logic [DEV_W-1:0] g2);
    return (rx == ind) || (rx == g1) || (rx == g2);
  endfunction

  // pointer after a data byte; natural 7-bit wrap
  function automatic logic [REG_AW-1:0] ptr_step(input logic [REG_AW-1:0] p,
                                                 input logic inc);
    return inc ? REG_AW'(p + 1'b1) : p;
  endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign dout = stg[STAGES-1];
  assign rise = dout & ~prev;
  assign fall = ~dout & prev;

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sel_fall,
  input  logic              sck_rise,
  input  logic              sdi_s,
  input  logic [DEV_W-1:0]  ind_addr,
  input  logic [DEV_W-1:0]  g1_addr,
  input  logic [DEV_W-1:0]  g2_addr,
  output logic              wr_stb,
  output logic [REG_AW-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output frame_st_t         state,
  output logic [2:0]        bit_cnt,
  output logic              byte_done
);

  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] shift_next;
  logic [REG_AW-1:0] ptr;
  logic              inc_en;
  logic              live;
  logic              hit;

  assign live       = (state == ST_CHIP) || (state == ST_PTR) || (state == ST_DATA);
  assign shift_next = {shreg[BYTE_W-2:0], sdi_s};
  assign byte_done  = sck_rise && !sel_s && live && (bit_cnt == 3'd7);
  assign hit        = chip_hit(shift_next[BYTE_W-1:1], ind_addr, g1_addr, g2_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      inc_en  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (sel_s) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
      end else if (sel_fall) begin
        state   <= ST_CHIP;
        bit_cnt <= '0;
      end else if (sck_rise && live) begin
        shreg   <= shift_next;
        bit_cnt <= 3'(bit_cnt + 3'd1);
        if (byte_done) begin
          unique case (state)
            ST_CHIP: state <= (!shift_next[0] && hit) ? ST_PTR : ST_LOCK;
            ST_PTR: begin
              inc_en <= shift_next[BYTE_W-1];
              ptr    <= shift_next[REG_AW-1:0];
              state  <= ST_DATA;
            end
            ST_DATA: begin
              wr_stb  <= 1'b1;
              wr_addr <= ptr;
              wr_data <= shift_next;
              ptr     <= ptr_step(ptr, inc_en);
            end
            default: state <= ST_LOCK;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
  import spi_regport_pkg::*;
#(
  parameter int               DEPTH   = 128,
  parameter logic [REG_AW-1:0] IND_LOC = 7'h1B,
  parameter logic [REG_AW-1:0] G1_LOC  = 7'h1A,
  parameter logic [REG_AW-1:0] G2_LOC  = 7'h19,
  parameter logic [DEV_W-1:0]  IND_RST = 7'h40,
  parameter logic [DEV_W-1:0]  G1_RST  = 7'h7F,
  parameter logic [DEV_W-1:0]  G2_RST  = 7'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [DEV_W-1:0]  ind_addr,
  output logic [DEV_W-1:0]  g1_addr,
  output logic [DEV_W-1:0]  g2_addr
);

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      mem[IND_LOC] <= {1'b0, IND_RST};
      mem[G1_LOC]  <= {1'b0, G1_RST};
      mem[G2_LOC]  <= {1'b0, G2_RST};
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign ind_addr = mem[IND_LOC][DEV_W-1:0];
  assign g1_addr  = mem[G1_LOC][DEV_W-1:0];
  assign g2_addr  = mem[G2_LOC][DEV_W-1:0];

endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sel_n,
  input  logic        spi_sck,
  input  logic        spi_sdi,
  output logic        wr_stb,
  output logic [6:0]  wr_addr,
  output logic [7:0]  wr_data
);

  localparam int NSIG = 3;

  logic [NSIG-1:0] pins_s, pins_rise, pins_fall;
  logic            sel_s, sel_fall, sck_rise, sdi_s;
  logic [DEV_W-1:0] ind_addr, g1_addr, g2_addr;
  frame_st_t       fr_state;
  logic [2:0]      bit_cnt;
  logic            byte_done;

  spi_regport_sync #(
    .WIDTH  (NSIG),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_sel_n, spi_sck, spi_sdi}),
    .dout (pins_s),
    .rise (pins_rise),
    .fall (pins_fall)
  );

  assign sel_s    = pins_s[2];
  assign sel_fall = pins_fall[2];
  assign sck_rise = pins_rise[1];
  assign sdi_s    = pins_s[0];

  spi_regport_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_s    (sel_s),
    .sel_fall (sel_fall),
    .sck_rise (sck_rise),
    .sdi_s    (sdi_s),
    .ind_addr (ind_addr),
    .g1_addr  (g1_addr),
    .g2_addr  (g2_addr),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .state    (fr_state),
    .bit_cnt  (bit_cnt),
    .byte_done(byte_done)
  );

  spi_regport_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_stb),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .ind_addr(ind_addr),
    .g1_addr (g1_addr),
    .g2_addr (g2_addr)
  );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
  import spi_regport_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sel_s,
  input frame_st_t  state,
  input logic [2:0] bit_cnt,
  input logic       byte_done,
  input logic       wr_stb
);

  // R9
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_s) |-> (state == ST_IDLE && bit_cnt == 3'd0));

  // R4
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK) |-> !wr_stb);

  // R5
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R5
  stb_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(state) == ST_DATA && $past(byte_done)));

endmodule

bind spi_regport spi_regport_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_s    (sel_s),
  .state    (fr_state),
  .bit_cnt  (bit_cnt),
  .byte_done(byte_done),
  .wr_stb   (wr_stb)
);

// File: tb/test_spi_regport.sv
module test_spi_regport;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int NVEC       = 7;

  // {device[6:0], rw, ptr[7:0], d0, d1, d2, expected write count[1:0]}
  localparam logic [41:0] VEC [NVEC] = '{
    {7'h40, 1'b0, 8'h05, 8'hA1, 8'hA2, 8'hA3, 2'd3},
    {7'h40, 1'b0, 8'h85, 8'hB1, 8'hB2, 8'hB3, 2'd3},
    {7'h40, 1'b0, 8'hFE, 8'hC1, 8'hC2, 8'hC3, 2'd3},
    {7'h40, 1'b1, 8'h05, 8'hD1, 8'hD2, 8'hD3, 2'd0},
    {7'h41, 1'b0, 8'h05, 8'hE1, 8'hE2, 8'hE3, 2'd0},
    {7'h7F, 1'b0, 8'h90, 8'hF1, 8'hF2, 8'hF3, 2'd3},
    {7'h7E, 1'b0, 8'h20, 8'h11, 8'h12, 8'h13, 2'd3}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sel_n = 1'b1;
  logic       spi_sck = 1'b0;
  logic       spi_sdi = 1'b0;
  logic       wr_stb;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  int cap_n = 0;
  logic [6:0] cap_addr [8];
  logic [7:0] cap_data [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regport i_spi_regport (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sel_n(spi_sel_n),
    .spi_sck  (spi_sck),
    .spi_sdi  (spi_sdi),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      if (cap_n < 8) begin
        cap_addr[cap_n] = wr_addr;
        cap_data[cap_n] = wr_data;
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) spi_sdi = val[i];
      repeat (HALF_SCK) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HALF_SCK) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic open_frame();
    cap_n = 0;
    @(negedge clk) spi_sel_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (8) @(negedge clk);
    spi_sel_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_frame(input logic [6:0] dev, input logic rw, input logic [7:0] ptr,
                            input logic [23:0] data, input int nbytes);
    open_frame();
    send_bits({dev, rw}, 8);
    send_bits(ptr, 8);
    for (int k = 0; k < nbytes; k++) send_bits(data[23-8*k -: 8], 8);
    close_frame();
  endtask

  task automatic expect_one(input string tag, input logic [6:0] a, input logic [7:0] d);
    check(cap_n == 1, tag, cap_n, 1);
    if (cap_n == 1) begin
      check(cap_addr[0] == a, tag, cap_addr[0], a);
      check(cap_data[0] == d, tag, cap_data[0], d);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: strobe quiet after reset
    check(wr_stb == 1'b0, "R1 reset strobe", wr_stb, 0);
    check(cap_n == 0, "R1 reset no writes", cap_n, 0);

    // table: R2 R3 R4 R5 R6 R7, plus R1 reset addresses 40h/7Fh/7Eh
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0] dev;
      logic       rw, inc;
      logic [7:0] ptr;
      logic [23:0] dat;
      int         nexp;
      logic [6:0] ea;
      {dev, rw, ptr, dat} = VEC[v][41:2];
      nexp = int'(VEC[v][1:0]);
      inc  = ptr[7];
      send_frame(dev, rw, ptr, dat, 3);
      check(cap_n == nexp, $sformatf("R3 R4 vector %0d count", v), cap_n, nexp);
      for (int k = 0; k < nexp && k < cap_n; k++) begin
        ea = inc ? 7'(ptr[6:0] + 7'(k)) : ptr[6:0];
        check(cap_addr[k] == ea, $sformatf("R6 R7 vector %0d addr %0d", v, k), cap_addr[k], ea);
        check(cap_data[k] == dat[23-8*k -: 8], $sformatf("R2 R5 vector %0d data %0d", v, k),
              cap_data[k], dat[23-8*k -: 8]);
      end
    end

    // R8: move individual address to 22h
    send_frame(7'h40, 1'b0, 8'h1B, {8'h22, 16'h0}, 1);
    expect_one("R8 write 1Bh", 7'h1B, 8'h22);
    send_frame(7'h40, 1'b0, 8'h01, {8'h5A, 16'h0}, 1);
    check(cap_n == 0, "R8 old address refused", cap_n, 0);
    send_frame(7'h22, 1'b0, 8'h01, {8'h5A, 16'h0}, 1);
    expect_one("R8 new address accepted", 7'h01, 8'h5A);

    // R8: move group 1 address to 33h
    send_frame(7'h22, 1'b0, 8'h1A, {8'h33, 16'h0}, 1);
    expect_one("R8 write 1Ah", 7'h1A, 8'h33);
    send_frame(7'h7F, 1'b0, 8'h02, {8'h44, 16'h0}, 1);
    check(cap_n == 0, "R8 old group refused", cap_n, 0);
    send_frame(7'h33, 1'b0, 8'h02, {8'h44, 16'h0}, 1);
    expect_one("R8 group accepted", 7'h02, 8'h44);

    // R9: partial byte dropped, next frame aligned
    open_frame();
    send_bits({7'h22, 1'b0}, 8);
    send_bits(8'h08, 8);
    send_bits(8'h66, 8);
    send_bits(8'hF0, 4);
    close_frame();
    expect_one("R9 partial byte dropped", 7'h08, 8'h66);
    send_frame(7'h22, 1'b0, 8'h09, {8'h77, 16'h0}, 1);
    expect_one("R9 next frame aligned", 7'h09, 8'h77);

    // R4: locked frame with header-like data, then fresh frame works
    send_frame(7'h22, 1'b1, {1'b0, 7'h22}, {8'h44, 8'h0C, 8'h99}, 3);
    check(cap_n == 0, "R4 read-flag lock", cap_n, 0);
    send_frame(7'h33, 1'b0, 8'h0C, {8'h99, 16'h0}, 1);
    expect_one("R4 release after select", 7'h0C, 8'h99);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
    $finish;
  end

endmodule